// File: doc/BRIEF.md
# Two-Step Refresh Watchdog Timer

This block is a software watchdog for a small microcontroller. A 16-bit up-counter advances once per prescaler tick. Each tick lasts either 24 or 384 input clocks. A bit in the 8-bit reload register picks the rate. The watchdog is idle and cleared after reset. A start write begins counting and loads the counter from the reload register. Once counting has begun, only the asynchronous active-low reset can halt it.

Software keeps the watchdog alive with a two-write sequence. First it writes the arm strobe. Then it writes the start strobe no more than 12 clocks later. The counter is then reloaded and the prescaler restarts. If the window runs out, the arm clears by itself and the late start write has no effect. A start write with no pending arm has no effect while the block is running.

When the counter reaches the terminal value 0x7CFF, a registered reset request goes high. A sticky status bit is set at the same time. The request drops once the counter moves on. The status bit holds until software clears it or reset occurs.

Top module: `wdt_two_step`

## Requirements
- R1: After reset the counter output is 0, the reset request is 0 and the status bit is 0. The counter stays at 0 until a start write arrives.
- R2: A start write while stopped begins counting. It loads the counter with reload bits 6:0 in counter bits 14:8, and zeros in bit 15 and in bits 7:0.
- R3: With reload bit 7 at 0, the counter increments exactly 24 clocks after a load and every 24 clocks after that. With reload bit 7 at 1, the interval is 384 clocks.
- R4: Once running, no input other than reset stops the counter from advancing.
- R5: An arm write followed by a start write 1 to 12 clocks later reloads the counter as in R2 and restarts the tick interval.
- R6: A start write 13 or more clocks after the arm write does not reload the counter, because the arm has expired.
- R7: While running, a start write with no pending arm does not reload the counter. A reload-register write alone does not change the counter either.
- R8: The reset request rises one clock after the counter becomes 0x7CFF. It falls one clock after the counter leaves 0x7CFF.
- R9: The status bit sets together with the reset request. It holds until a status-clear strobe or reset.
- R10: Asserting reset while running returns the block at once to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_wr | input | 1 | Arm write strobe, the first half of a refresh |
| start_wr | input | 1 | Start write strobe: starts the watchdog, or completes a refresh |
| reload_wr | input | 1 | Reload register write strobe |
| reload_val | input | 8 | Reload value: bit 7 selects the slow rate, bits 6:0 give the counter upper bits |
| sts_clr | input | 1 | Clears the status bit |
| cnt_o | output | 16 | Current counter value |
| sts_o | output | 1 | Sticky status bit, set at the terminal count |
| rst_req_o | output | 1 | Registered reset request |

## Verification
The assertions check several rules on every cycle:
- the counter stays at zero while stopped, and running never clears;
- between loads the counter only holds or steps by one;
- a tick is never followed directly by another;
- the arm window counter stays in range, and a completed refresh consumes the arm;
- the status bit is set whenever the reset request rises.

Only the bench scenarios can show the rest. These are the exact 24- and 384-clock tick intervals, and the acceptance of refreshes at 1, 11 and 12 clocks against their rejection at 13 and 20. They also cover the one-clock lag of the reset request on entering and leaving 0x7CFF, and the fact that a start with no pending arm leaves the counter alone.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned WDT_CNT_W    = 16;
  localparam int unsigned WDT_RLD_W    = 8;
  localparam int unsigned WDT_FAST_DIV = 24;
  localparam int unsigned WDT_SLOW_MUL = 16;
  localparam int unsigned WDT_WIN      = 12;
  localparam logic [WDT_CNT_W-1:0] WDT_TERM = 16'h7CFF;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int unsigned FAST_DIV = 24,
  parameter int unsigned SLOW_MUL = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  input  logic slow,
  output logic tick
);
  localparam int unsigned SLOW_DIV = FAST_DIV * SLOW_MUL;
  localparam int unsigned PC_W     = $clog2(SLOW_DIV);
  localparam logic [PC_W-1:0] FAST_LAST = PC_W'(FAST_DIV - 1);
  localparam logic [PC_W-1:0] SLOW_LAST = PC_W'(SLOW_DIV - 1);

  logic [PC_W-1:0] pc_q, pc_d;
  logic [PC_W-1:0] last;

  always_comb begin
    last = slow ? SLOW_LAST : FAST_LAST;
    tick = en && !clr && (pc_q >= last);
    if (clr || !en || tick) pc_d = '0;
    else                    pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  // R3: ticks are spaced by at least one full interval
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/wdt_refresh.sv
module wdt_refresh #(
  parameter int unsigned WIN = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_wr,
  input  logic start_wr,
  output logic refresh,
  output logic armed
);
  localparam int unsigned WIN_W = $clog2(WIN + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN - 1);

  logic             armed_q, armed_d;
  logic [WIN_W-1:0] win_q, win_d;

  always_comb begin
    refresh = armed_q && start_wr;
    armed_d = armed_q;
    win_d   = win_q;
    if (arm_wr) begin
      armed_d = 1'b1;
      win_d   = '0;
    end else if (refresh) begin
      armed_d = 1'b0;
      win_d   = '0;
    end else if (armed_q) begin
      if (win_q == WIN_LAST) begin
        armed_d = 1'b0;
        win_d   = '0;
      end else begin
        win_d = win_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      win_q   <= '0;
    end else begin
      armed_q <= armed_d;
      win_q   <= win_d;
    end
  end

  assign armed = armed_q;

  // R6: the window counter never runs past the window
  a_r6_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (win_q < WIN_W'(WIN)));
  // R5: a completed refresh consumes the arm
  a_r5_arm_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh && !arm_wr) |=> !armed_q);
endmodule

// File: rtl/wdt_two_step.sv
module wdt_two_step
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W    = WDT_CNT_W,
  parameter int unsigned RLD_W    = WDT_RLD_W,
  parameter int unsigned FAST_DIV = WDT_FAST_DIV,
  parameter int unsigned SLOW_MUL = WDT_SLOW_MUL,
  parameter int unsigned WIN      = WDT_WIN,
  parameter logic [CNT_W-1:0] TERM = WDT_TERM
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_wr,
  input  logic             start_wr,
  input  logic             reload_wr,
  input  logic [RLD_W-1:0] reload_val,
  input  logic             sts_clr,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sts_o,
  output logic             rst_req_o
);
  localparam int unsigned LO_W  = CNT_W / 2;
  localparam int unsigned PAD_W = CNT_W - LO_W - (RLD_W - 1);

  logic [RLD_W-1:0] rld_q, rld_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, load_word;
  logic             run_q, run_d;
  logic             req_q, req_d;
  logic             sts_q, sts_d;
  logic             tick, refresh, armed, do_load, at_term;

  wdt_refresh #(.WIN(WIN)) u_refresh (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_wr   (arm_wr),
    .start_wr (start_wr),
    .refresh  (refresh),
    .armed    (armed)
  );

  wdt_prescale #(.FAST_DIV(FAST_DIV), .SLOW_MUL(SLOW_MUL)) u_prescale (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (run_q),
    .clr   (do_load),
    .slow  (rld_q[RLD_W-1]),
    .tick  (tick)
  );

  always_comb begin
    load_word = {{PAD_W{1'b0}}, rld_q[RLD_W-2:0], {LO_W{1'b0}}};
    do_load   = start_wr && (!run_q || refresh);
    at_term   = (cnt_q == TERM);

    rld_d = reload_wr ? reload_val : rld_q;
    run_d = run_q || start_wr;

    if (do_load)   cnt_d = load_word;
    else if (tick) cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;

    req_d = at_term;
    sts_d = at_term || (sts_q && !sts_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      req_q <= 1'b0;
      sts_q <= 1'b0;
    end else begin
      rld_q <= rld_d;
      cnt_q <= cnt_d;
      run_q <= run_d;
      req_q <= req_d;
      sts_q <= sts_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign sts_o     = sts_q;
  assign rst_req_o = req_q;

  // R1: a stopped watchdog holds a zero count
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (cnt_q == '0));
  // R4: once running, only reset stops it
  a_r4_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> run_q);
  // R3: between loads the count holds or steps by one
  a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    !do_load |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
  // R9: status is set whenever the request rises
  a_r9_sts_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> sts_q);
endmodule

// File: tb/wdt_two_step_tb.sv
module wdt_two_step_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        arm_wr, start_wr, reload_wr, sts_clr;
  logic [7:0]  reload_val;
  logic [15:0] cnt_o;
  logic        sts_o, rst_req_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  wdt_two_step u_dut (
    .clk(clk), .rst_n(rst_n), .arm_wr(arm_wr), .start_wr(start_wr),
    .reload_wr(reload_wr), .reload_val(reload_val), .sts_clr(sts_clr),
    .cnt_o(cnt_o), .sts_o(sts_o), .rst_req_o(rst_req_o)
  );

  // vector: {reload byte, cycles from arm to start, expect reload}
  localparam logic [13:0] VECS [0:5] = '{
    {8'h05, 5'd1,  1'b1},
    {8'h12, 5'd12, 1'b1},
    {8'h20, 5'd13, 1'b0},
    {8'h33, 5'd11, 1'b1},
    {8'h44, 5'd20, 1'b0},
    {8'h3A, 5'd6,  1'b1}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulse_arm();
    arm_wr = 1'b1; @(negedge clk); arm_wr = 1'b0;
  endtask
  task automatic pulse_start();
    start_wr = 1'b1; @(negedge clk); start_wr = 1'b0;
  endtask
  task automatic pulse_clr();
    sts_clr = 1'b1; @(negedge clk); sts_clr = 1'b0;
  endtask
  task automatic wr_reload(input logic [7:0] v);
    reload_val = v; reload_wr = 1'b1; @(negedge clk); reload_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  logic [7:0] prev_hi;

  initial begin
    rst_n = 1'b0; arm_wr = 0; start_wr = 0; reload_wr = 0; sts_clr = 0; reload_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 count", cnt_o, 16'h0000);
    check("R1 request", {15'b0, rst_req_o}, 16'h0);
    check("R1 status", {15'b0, sts_o}, 16'h0);
    wr_reload(8'h7C);
    repeat (100) @(negedge clk);
    check("R1 idle count", cnt_o, 16'h0000);

    pulse_start();
    check("R2 start load", cnt_o, 16'h7C00);
    repeat (23) @(negedge clk);
    check("R3 fast hold", cnt_o, 16'h7C00);
    @(negedge clk);
    check("R3 fast tick", cnt_o, 16'h7C01);

    for (int i = 0; i < 7000 && cnt_o != 16'h7CFF; i++) @(negedge clk);
    check("R8 reach term", cnt_o, 16'h7CFF);
    check("R8 lag", {15'b0, rst_req_o}, 16'h0);
    @(negedge clk);
    check("R8 request high", {15'b0, rst_req_o}, 16'h1);
    check("R9 status set", {15'b0, sts_o}, 16'h1);
    repeat (23) @(negedge clk);
    check("R8 left term", cnt_o, 16'h7D00);
    check("R8 request held", {15'b0, rst_req_o}, 16'h1);
    @(negedge clk);
    check("R8 request low", {15'b0, rst_req_o}, 16'h0);
    check("R9 status sticky", {15'b0, sts_o}, 16'h1);
    pulse_clr();
    check("R9 status cleared", {15'b0, sts_o}, 16'h0);

    wr_reload(8'h10);
    check("R7 reload write only", {8'h0, cnt_o[15:8]}, 16'h007D);
    pulse_start();
    check("R7 start without arm", {8'h0, cnt_o[15:8]}, 16'h007D);

    prev_hi = 8'h7D;
    for (int v = 0; v < 6; v++) begin
      logic [7:0] val;
      logic [4:0] dly;
      logic       acc;
      {val, dly, acc} = VECS[v];
      wr_reload(val);
      pulse_arm();
      repeat (int'(dly) - 1) @(negedge clk);
      pulse_start();
      if (acc) begin
        check($sformatf("R5 refresh delay %0d", dly), cnt_o, {1'b0, val[6:0], 8'h00});
        prev_hi = {1'b0, val[6:0]};
      end else begin
        check($sformatf("R6 late start delay %0d", dly), {8'h0, cnt_o[15:8]}, {8'h0, prev_hi});
      end
    end

    wr_reload(8'h85);
    pulse_arm();
    pulse_start();
    check("R5 refresh slow", cnt_o, 16'h0500);
    repeat (383) @(negedge clk);
    check("R3 slow hold", cnt_o, 16'h0500);
    @(negedge clk);
    check("R3 R4 slow tick", cnt_o, 16'h0501);
    pulse_arm();
    repeat (400) @(negedge clk);
    check("R4 still running", {15'b0, cnt_o > 16'h0501}, 16'h1);

    #1 rst_n = 1'b0;
    #1 check("R10 async clear", cnt_o, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (50) @(negedge clk);
    check("R10 count", cnt_o, 16'h0000);
    check("R10 request", {15'b0, rst_req_o}, 16'h0);
    check("R10 status", {15'b0, sts_o}, 16'h0);

    finish_run();
  end
endmodule